// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds a set of independent down-counters behind one small register slave. Each channel has a one-byte control register and a full-width count register. Software normally programs a channel in three steps: turn it off, load a count, then turn it on with a mode. While a channel is on, its counter drops by one on every clock. Three behaviours are available. In free-running mode the counter wraps and never signals. In single-shot mode it signals once, at zero, and then stops. In repeating mode it reloads the programmed count at zero and signals again every period.

Every channel drives its own interrupt line. The line is a one-clock pulse in the cycle after the counter expires. A read of a count register returns the live counter value, so software can take timestamps from a free-running channel. Reads come back one clock after the request, flagged by a valid strobe. Writes take effect at the clock edge where they are sampled.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every control register and every counter reads as zero, all interrupt lines are low and the read-valid strobe is low.
- R2: Bits [5:3] of the byte address select the channel. Address bit 2 selects the count register (1) or the control register (0). Bits [1:0] are ignored. A read request returns its data on bus_rdata with bus_rvalid high in the following cycle only.
- R3: Writing a channel's count register loads both its counter and its reload value, whether the channel is on or off. A count read returns the counter value as it stood just before the sampling edge.
- R4: Control bit 0 is the enable. Control bits [5:4] are the mode: 0 or 3 is free-running, 1 is single-shot, 2 is repeating. Other write bits are dropped. A control read returns the enable and the mode at those positions, with every other bit zero.
- R5: An enabled channel decrements by exactly one per clock. In a cycle where either of its registers is written, it neither decrements nor expires.
- R6: In free-running mode the counter wraps from 0 to all ones, and the channel never raises its interrupt.
- R7: In single-shot mode with count N, the interrupt is high for exactly one cycle, N+1 clocks after the enabling write. The enable bit then reads 0 and the counter holds at 0.
- R8: In repeating mode with count N, the counter reloads N on expiry, and the interrupt pulses for one cycle every N+1 clocks while the channel stays enabled.
- R9: A count of zero in single-shot or repeating mode expires on the first enabled clock.
- R10: A write to one channel leaves every other channel's counter and interrupt untouched. Each interrupt line reflects only its own channel.
- R11: A disabled channel holds its counter value and keeps its interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus request strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | CNT_W (32) | Write data; control writes use bits [7:0] |
| bus_rdata | output | CNT_W (32) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | NUM_CH (8) | Per-channel one-cycle expiry pulse |

## Verification
Each mode is driven on a different channel with small counts. This way a pulse arriving one clock early or late, or landing on the wrong line, shows as a miscompare. Repeated reads of a running channel, taken at known clock distances, separate a live counter from a latched value and confirm that register-write cycles suppress the decrement. Separate cases cover a count of two in free-running mode (wrap with no interrupt), a count of zero in single-shot mode (immediate expiry), and a three-count repeating run (reload value and period). Writes to one channel that are interleaved with reads of another show whether state leaks between channels.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  typedef enum logic [1:0] {
    TM_FREE     = 2'd0,
    TM_ONCE     = 2'd1,
    TM_PERIOD   = 2'd2,
    TM_FREE_ALT = 2'd3
  } tmr_mode_e;

  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_MODE_LSB  = 4;
  localparam int CTL_BYTE_W    = 8;
  localparam int SEL_CNT_BIT   = 2;
  localparam int CH_STRIDE_LOG = 3;

  function automatic logic mode_expires(tmr_mode_e m);
    return (m == TM_ONCE) || (m == TM_PERIOD);
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_bank_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_we,
  input  logic                  cnt_we,
  input  logic [CTL_BYTE_W-1:0] ctl_wdata,
  input  logic [CNT_W-1:0]      cnt_wdata,
  output logic                  en_o,
  output tmr_mode_e             mode_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [CNT_W-1:0]      load_o,
  output logic                  irq_o
);
  logic             en_q, en_d;
  tmr_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic             irq_q, irq_d;
  logic             expire;
  logic             upd_en;

  assign expire = en_q && mode_expires(mode_q) && (cnt_q == '0);
  assign upd_en = ctl_we || cnt_we || en_q;

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    load_d = load_q;
    irq_d  = 1'b0;
    if (ctl_we || cnt_we) begin
      if (ctl_we) begin
        en_d   = ctl_wdata[CTL_EN_BIT];
        mode_d = tmr_mode_e'(ctl_wdata[CTL_MODE_LSB +: 2]);
      end
      if (cnt_we) begin
        cnt_d  = cnt_wdata;
        load_d = cnt_wdata;
      end
    end else if (en_q) begin
      if (expire) begin
        irq_d = 1'b1;
        if (mode_q == TM_PERIOD) begin
          cnt_d = load_q;
        end else begin
          en_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= TM_FREE;
      cnt_q  <= '0;
      load_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (upd_en) begin
        en_q   <= en_d;
        mode_q <= mode_d;
        cnt_q  <= cnt_d;
        load_q <= load_d;
      end
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tmr_bus_port.sv
module tmr_bus_port
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ch_en   [NUM_CH],
  input  tmr_mode_e         ch_mode [NUM_CH],
  input  logic [CNT_W-1:0]  ch_cnt  [NUM_CH],
  output logic [NUM_CH-1:0] ctl_we,
  output logic [NUM_CH-1:0] cnt_we,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  localparam int IDX_W = ADDR_W - CH_STRIDE_LOG;
  localparam logic [IDX_W:0] NUM_CH_L = NUM_CH[IDX_W:0];

  logic [IDX_W-1:0] ch_idx;
  logic             is_cnt;
  logic             idx_ok;
  logic             rd_req;
  logic             wr_req;
  logic [CNT_W-1:0] rdata_d, rdata_q;
  logic             rvalid_q;
  logic             unused_addr_lsb;

  assign ch_idx          = bus_addr[ADDR_W-1:CH_STRIDE_LOG];
  assign is_cnt          = bus_addr[SEL_CNT_BIT];
  assign idx_ok          = ({1'b0, ch_idx} < NUM_CH_L);
  assign rd_req          = bus_req && !bus_wr;
  assign wr_req          = bus_req && bus_wr;
  assign unused_addr_lsb = ^bus_addr[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
    assign ctl_we[g] = wr_req && (ch_idx == IDX_W'(g)) && !is_cnt;
    assign cnt_we[g] = wr_req && (ch_idx == IDX_W'(g)) &&  is_cnt;
  end

  always_comb begin
    rdata_d = '0;
    if (idx_ok) begin
      if (is_cnt) begin
        rdata_d = ch_cnt[ch_idx];
      end else begin
        rdata_d = CNT_W'({ch_mode[ch_idx], 3'b000, ch_en[ch_idx]});
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = $clog2(NUM_CH) + CH_STRIDE_LOG
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CH-1:0] irq
);
  logic              rst_n;
  logic [NUM_CH-1:0] ctl_we;
  logic [NUM_CH-1:0] cnt_we;
  logic              ch_en   [NUM_CH];
  tmr_mode_e         ch_mode [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
  logic [CNT_W-1:0]  ch_load [NUM_CH];

  tmr_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  tmr_bus_port #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) i_bus_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .ch_en      (ch_en),
    .ch_mode    (ch_mode),
    .ch_cnt     (ch_cnt),
    .ctl_we     (ctl_we),
    .cnt_we     (cnt_we),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(
      .CNT_W (CNT_W)
    ) i_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we[g]),
      .cnt_we    (cnt_we[g]),
      .ctl_wdata (bus_wdata[CTL_BYTE_W-1:0]),
      .cnt_wdata (bus_wdata),
      .en_o      (ch_en[g]),
      .mode_o    (ch_mode[g]),
      .cnt_o     (ch_cnt[g]),
      .load_o    (ch_load[g]),
      .irq_o     (irq[g])
    );
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic [NUM_CH-1:0] irq,
  input logic              ch_en   [NUM_CH],
  input tmr_mode_e         ch_mode [NUM_CH],
  input logic [CNT_W-1:0]  ch_cnt  [NUM_CH],
  input logic [CNT_W-1:0]  ch_load [NUM_CH]
);
  localparam int IDX_W = ADDR_W - CH_STRIDE_LOG;

  logic unused_lsb;
  assign unused_lsb = ^bus_addr[CH_STRIDE_LOG-1:0];

  // R2: read data strobe follows a read request by exactly one cycle
  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_wr) |=> !bus_rvalid);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic hit;
    logic free_mode;
    assign hit = bus_req && bus_wr &&
                 (bus_addr[ADDR_W-1:CH_STRIDE_LOG] == IDX_W'(g));
    assign free_mode = (ch_mode[g] == TM_FREE) || (ch_mode[g] == TM_FREE_ALT);

    assert_free_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[g] && free_mode && !hit) |=> (ch_cnt[g] == $past(ch_cnt[g]) - 1'b1));

    assert_free_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[g] && free_mode && !hit) |=> !irq[g]);

    assert_once_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[g] && (ch_mode[g] == TM_ONCE) && (ch_cnt[g] == '0) && !hit)
      |=> (irq[g] && !ch_en[g] && (ch_cnt[g] == '0)));

    assert_period_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[g] && (ch_mode[g] == TM_PERIOD) && (ch_cnt[g] == '0) && !hit)
      |=> (irq[g] && (ch_cnt[g] == $past(ch_load[g]))));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[g] && !hit) |=> ($stable(ch_cnt[g]) && !irq[g]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) i_tmr_bank_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .irq        (irq),
  .ch_en      (ch_en),
  .ch_mode    (ch_mode),
  .ch_cnt     (ch_cnt),
  .ch_load    (ch_load)
);

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 6;

  logic              clk;
  logic              arst_n;
  logic              bus_req;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [CNT_W-1:0]  bus_wdata;
  logic [CNT_W-1:0]  bus_rdata;
  logic              bus_rvalid;
  logic [NUM_CH-1:0] irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  tmr_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_tmr_bank (
    .clk(clk), .arst_n(arst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (arst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected rvalid", 32'h1, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  function automatic logic [ADDR_W-1:0] adr(int ch, bit is_cnt);
    return ADDR_W'(ch * 8 + (is_cnt ? 4 : 0));
  endfunction

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    arst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    check("R1 irq in reset", 32'(irq), 32'h0);
    check("R1 rvalid in reset", 32'(bus_rvalid), 32'h0);
    arst_n = 1'b1;
    idle(4);

    // R1: every register reads zero after reset
    for (int c = 0; c < NUM_CH; c++) begin
      bus_read(adr(c, 0), 32'h0, "R1 control after reset");
      bus_read(adr(c, 1), 32'h0, "R1 count after reset");
    end
    check("R1 irq after reset", 32'(irq), 32'h0);

    // R3 R5 R2: live count on a free-running channel
    bus_write(adr(1, 1), 32'd100);
    bus_write(adr(1, 0), 32'h01);
    bus_read(adr(1, 1), 32'd100, "R3 live count first read");
    bus_read(adr(1, 1), 32'd99,  "R5 decrement per clock");
    idle(5);
    bus_read(adr(1, 1), 32'd93,  "R5 decrement after idle");
    bus_read(adr(1, 1) + 1, 32'd92, "R2 low address bits ignored");
    // R11 R5: disable write suppresses decrement, counter then holds
    bus_write(adr(1, 0), 32'h00);
    idle(4);
    bus_read(adr(1, 1), 32'd91, "R11 disabled counter holds");
    bus_read(adr(1, 0), 32'h0,  "R4 control reads disabled");
    check("R11 no irq while disabled", 32'(irq), 32'h0);

    // R6: wrap in free-running mode without interrupt
    bus_write(adr(2, 1), 32'd2);
    bus_write(adr(2, 0), 32'h01);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 no irq in free mode", 32'(irq), 32'h0);
    end
    bus_read(adr(2, 1), 32'hFFFF_FFFF, "R6 wrap to all ones");
    bus_read(adr(2, 1), 32'hFFFF_FFFE, "R6 keeps counting after wrap");
    bus_write(adr(2, 0), 32'h00);

    // R4 R6: mode 3 acts as free-running, unused control bits dropped
    bus_write(adr(6, 0), 32'hFFFF_FFFF);
    bus_read(adr(6, 0), 32'h31, "R4 control readback fields");
    bus_read(adr(6, 1), 32'hFFFF_FFFF, "R6 mode 3 wraps from zero");
    check("R6 mode 3 no irq", 32'(irq), 32'h0);
    bus_write(adr(6, 0), 32'h00);

    // R7 R10: single-shot, count 5
    bus_write(adr(3, 1), 32'd5);
    bus_write(adr(3, 0), 32'h11);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 irq not yet", 32'(irq), 32'h0);
    end
    @(negedge clk);
    check("R7 R10 single-shot pulse on own line", 32'(irq), 32'h08);
    @(negedge clk);
    check("R7 pulse lasts one cycle", 32'(irq), 32'h0);
    bus_read(adr(3, 0), 32'h10, "R7 enable cleared after expiry");
    bus_read(adr(3, 1), 32'h0,  "R7 counter at zero");
    idle(3);
    bus_read(adr(3, 1), 32'h0,  "R7 counter holds zero");
    check("R7 no second pulse", 32'(irq), 32'h0);

    // R9: zero count expires on first enabled clock
    bus_write(adr(4, 1), 32'd0);
    bus_write(adr(4, 0), 32'h11);
    @(negedge clk);
    check("R9 zero count immediate expiry", 32'(irq), 32'h10);
    @(negedge clk);
    check("R9 single pulse", 32'(irq), 32'h0);
    bus_read(adr(4, 0), 32'h10, "R9 enable cleared");

    // R8: repeating mode, count 3 -> period 4
    bus_write(adr(0, 1), 32'd3);
    bus_write(adr(0, 0), 32'h21);
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check("R8 quiet between pulses", 32'(irq), 32'h0);
      end
      @(negedge clk);
      check("R8 periodic pulse", 32'(irq), 32'h01);
    end
    bus_read(adr(0, 1), 32'd3, "R8 reload value after expiry");
    bus_write(adr(0, 0), 32'h00);
    idle(2);
    bus_read(adr(0, 1), 32'd2, "R8 R11 held after disable");
    check("R8 no pulse after disable", 32'(irq), 32'h0);

    // R10 R3: other channels unaffected, count written while disabled
    bus_write(adr(5, 1), 32'd50);
    bus_write(adr(5, 0), 32'h01);
    bus_write(adr(7, 1), 32'h0000_1234);
    bus_read(adr(7, 1), 32'h0000_1234, "R3 count write while disabled");
    bus_read(adr(5, 1), 32'd48, "R10 neighbour write leaves counter");
    bus_read(adr(7, 0), 32'h0, "R10 control untouched");
    bus_write(adr(5, 0), 32'h00);
    bus_read(adr(1, 1), 32'd91, "R10 earlier channel still held");
    check("R10 all irq low", 32'(irq), 32'h0);

    idle(3);
    check("R2 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1;
    finish_run();
  end
endmodule